// File: doc/BRIEF.md
# Decoupled Tag-Data Cache Controller

This block keeps the tag side of a set-indexed cache whose data side is a single shared pool of slots, not a fixed slice per set. Every set offers twice as many tag ways as the data slots it would own in a conventional layout. Each valid tag way holds a forward link to the data slot that carries its block. Each occupied data slot holds a back link to the tag way that owns it. On a lookup hit, the block returns the slot index. On a miss, it picks a tag way in the indexed set and, where needed, a data slot taken from anywhere in the pool. It then relinks both sides and returns the newly assigned slot.

Free data slots are found by a rotating sweep over small per-slot reuse counters. Hits raise a slot's counter. The sweep lowers each nonzero counter it passes and stops at the first counter that is already zero. The sweep position is kept between misses. If the owner of the reclaimed slot lives in another set, that owner is invalidated through the back link. If the indexed set has no free tag way, its least recently used way gives up its own slot directly and no sweep takes place. Data storage, refill timing and coherence are outside this block.

Requests use a valid/ready handshake. `req_ready` is low while a miss is being serviced, and a request held valid during that time waits. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the consumer must take.

Top module: `decoupled_tag_cache`

## Requirements
- R1: An address carries the set index in its low SET_W bits and the tag above them. A request accepted (req_valid and req_ready high at a clock edge) that matches a valid tag way in its set gives rsp_valid=1, rsp_hit=1 and the linked slot on rsp_slot right after that same edge.
- R2: After a miss is accepted, req_ready stays low until the edge that raises its response, and no request is taken in that window. A request held valid meanwhile is neither answered nor installed.
- R3: Each hit raises the reuse counter of the slot it hits by one, saturating at 3.
- R4: On a miss that needs a slot, the sweep examines one slot per cycle, starting at the sweep position. It lowers each nonzero counter by one and picks the first slot whose counter is zero. The response comes k+2 cycles after acceptance, where k is the number of slots examined.
- R5: After a sweep, the sweep position moves to the slot after the chosen one (wrapping at the pool size). A miss served without a sweep leaves it unchanged.
- R6: A reclaimed slot may come from any set. The tag way that owned it is invalidated, so a later lookup of that block misses.
- R7: The incoming block takes the lowest-index invalid tag way of its set. If there is none, it takes the set's least recently used way (recency updated by hits and fills) and reuses that way's slot without a sweep, responding 2 cycles after acceptance.
- R8: A miss response has rsp_hit=0 and gives the assigned slot. The slot's counter restarts at 0.
- R9: After reset, all tag ways and slots are empty, every counter and the sweep position are 0, req_ready=1 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | TAG_W+SET_W | Block address: set index low, tag high |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 when the request hit |
| rsp_slot | output | SLOT_W | Data slot index linked to the block |

## Verification
A broken forward or back link shows up on the next response for that block. The block may hit on a slot already given to another address, or it may miss where the model still holds it. A wrong counter or sweep position shifts which slot a later miss receives and how many cycles it stays busy. That difference can appear several misses after the fault, so the bench drives long miss streams after building up hit counts. A reference model tracks the exact slot and latency of every response.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FILL = 2'd2
  } dtc_state_t;
endpackage

// File: rtl/dtc_age_set.sv
module dtc_age_set #(
  parameter int TWAYS  = 4,
  parameter int TWAY_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch,
  input  logic [TWAY_W-1:0] touch_way,
  output logic [TWAY_W-1:0] lru_way
);
  // age 0 = most recent, TWAYS-1 = least recent; ages always form a permutation
  logic [TWAY_W-1:0] age [TWAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < TWAYS; w++) age[w] <= TWAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < TWAYS; w++) begin
        if (TWAY_W'(w) == touch_way) age[w] <= '0;
        else if (age[w] < age[touch_way]) age[w] <= age[w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < TWAYS; w++)
      if (age[w] == TWAY_W'(TWAYS - 1)) lru_way = TWAY_W'(w);
  end
endmodule

// File: rtl/dtc_reuse_scan.sv
module dtc_reuse_scan #(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [SLOT_W-1:0] inc_slot,
  input  logic              step_en,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  output logic [SLOT_W-1:0] ptr,
  output logic              cur_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(NSLOT - 1);

  logic [CNT_W-1:0] cnt [NSLOT];

  assign cur_zero = (cnt[ptr] == '0);

  // inc (idle hit), step (sweep) and clr (fill) never coincide
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < NSLOT; i++) cnt[i] <= '0;
    end else begin
      if (inc_en && cnt[inc_slot] != CNT_MAX) cnt[inc_slot] <= cnt[inc_slot] + 1'b1;
      if (step_en) begin
        if (!cur_zero) cnt[ptr] <= cnt[ptr] - 1'b1;
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
      if (clr_en) cnt[clr_slot] <= '0;
    end
  end
endmodule

// File: rtl/decoupled_tag_cache.sv
module decoupled_tag_cache #(
  parameter int SET_W = 2,
  parameter int DWAYS = 2,
  parameter int TAG_W = 8,
  parameter int SLOT_W = $clog2((1 << SET_W) * DWAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [TAG_W+SET_W-1:0] req_addr,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [SLOT_W-1:0]      rsp_slot
);
  import dtc_pkg::*;

  localparam int SETS   = 1 << SET_W;
  localparam int TWAYS  = 2 * DWAYS;
  localparam int TWAY_W = $clog2(TWAYS);
  localparam int NSLOT  = SETS * DWAYS;

  dtc_state_t st;

  logic [SETS-1:0][TWAYS-1:0] tv;
  logic [TAG_W-1:0]  tt   [SETS][TWAYS];
  logic [SLOT_W-1:0] tfwd [SETS][TWAYS];
  logic [NSLOT-1:0]  slot_vld;
  logic [SET_W-1:0]  sown_set [NSLOT];
  logic [TWAY_W-1:0] sown_way [NSLOT];

  logic [SET_W-1:0]  q_set;
  logic [TAG_W-1:0]  q_tag;
  logic [TWAY_W-1:0] q_way;
  logic [SLOT_W-1:0] q_slot;

  logic [SET_W-1:0]  rq_set;
  logic [TAG_W-1:0]  rq_tag;
  logic              lk_hit, lk_free, acc, acc_hit;
  logic [TWAY_W-1:0] lk_way, free_way, touch_way;
  logic [SETS-1:0]   touch_vec;
  logic [TWAY_W-1:0] lru_all [SETS];
  logic [SLOT_W-1:0] scan_ptr;
  logic              scan_zero;

  assign rq_set    = req_addr[SET_W-1:0];
  assign rq_tag    = req_addr[TAG_W+SET_W-1:SET_W];
  assign req_ready = (st == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign acc_hit   = acc && lk_hit;

  always_comb begin
    lk_hit = 1'b0; lk_way = '0; lk_free = 1'b0; free_way = '0;
    for (int w = TWAYS - 1; w >= 0; w--) begin
      if (!tv[rq_set][w]) begin lk_free = 1'b1; free_way = TWAY_W'(w); end
      if (tv[rq_set][w] && tt[rq_set][w] == rq_tag) begin lk_hit = 1'b1; lk_way = TWAY_W'(w); end
    end
  end

  assign touch_way = (st == ST_FILL) ? q_way : lk_way;

  for (genvar s = 0; s < SETS; s++) begin : g_age
    assign touch_vec[s] = (acc_hit && rq_set == SET_W'(s)) ||
                          (st == ST_FILL && q_set == SET_W'(s));
    dtc_age_set #(.TWAYS(TWAYS), .TWAY_W(TWAY_W)) u_age (
      .clk(clk), .rst_n(rst_n), .touch(touch_vec[s]),
      .touch_way(touch_way), .lru_way(lru_all[s])
    );
  end

  dtc_reuse_scan #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .CNT_W(2)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .inc_en(acc_hit), .inc_slot(tfwd[rq_set][lk_way]),
    .step_en(st == ST_SCAN),
    .clr_en(st == ST_FILL), .clr_slot(q_slot),
    .ptr(scan_ptr), .cur_zero(scan_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      tv <= '0;
      slot_vld <= '0;
      q_set <= '0; q_tag <= '0; q_way <= '0; q_slot <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_slot <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < TWAYS; w++) begin
          tt[s][w] <= '0; tfwd[s][w] <= '0;
        end
      for (int i = 0; i < NSLOT; i++) begin
        sown_set[i] <= '0; sown_way[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (acc) begin
          if (lk_hit) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1;
            rsp_slot  <= tfwd[rq_set][lk_way];
          end else begin
            q_set <= rq_set; q_tag <= rq_tag;
            if (lk_free) begin
              q_way <= free_way;
              st    <= ST_SCAN;
            end else begin
              q_way  <= lru_all[rq_set];
              q_slot <= tfwd[rq_set][lru_all[rq_set]];
              st     <= ST_FILL;
            end
          end
        end
        ST_SCAN: if (scan_zero) begin
          q_slot <= scan_ptr;
          st     <= ST_FILL;
        end
        ST_FILL: begin
          // drop the former owner first; the new entry below wins if it is the same way
          if (slot_vld[q_slot]) tv[sown_set[q_slot]][sown_way[q_slot]] <= 1'b0;
          tv[q_set][q_way]   <= 1'b1;
          tt[q_set][q_way]   <= q_tag;
          tfwd[q_set][q_way] <= q_slot;
          slot_vld[q_slot]   <= 1'b1;
          sown_set[q_slot]   <= q_set;
          sown_way[q_slot]   <= q_way;
          rsp_valid <= 1'b1; rsp_hit <= 1'b0; rsp_slot <= q_slot;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int SETS   = 4,
  parameter int TWAYS  = 4,
  parameter int NSLOT  = 8,
  parameter int SET_W  = 2,
  parameter int TWAY_W = 2,
  parameter int SLOT_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       rsp_valid,
  input logic                       rsp_hit,
  input logic [SLOT_W-1:0]          rsp_slot,
  input logic [SLOT_W-1:0]          scan_ptr,
  input logic [NSLOT-1:0]           slot_vld,
  input logic [SET_W-1:0]           sown_set [NSLOT],
  input logic [TWAY_W-1:0]          sown_way [NSLOT],
  input logic [SETS-1:0][TWAYS-1:0] tv,
  input logic [SLOT_W-1:0]          tfwd [SETS][TWAYS]
);
  // R1: a hit answer follows an accepted request at the very next edge
  a_r1_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(req_valid && req_ready));

  // R2: every accepted request either answers at once or turns busy
  a_r2_accept_or_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || !req_ready);

  // R2: a miss answer closes a busy window
  a_r2_miss_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> $past(!req_ready));

  // R5: sweep position moves only while busy
  a_r5_ptr_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scan_ptr) |-> $past(!req_ready));

  // R6: the answered slot is owned by a valid tag way that links back to it
  a_r6_links_agree: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> slot_vld[rsp_slot] &&
                  tv[sown_set[rsp_slot]][sown_way[rsp_slot]] &&
                  tfwd[sown_set[rsp_slot]][sown_way[rsp_slot]] == rsp_slot);
endmodule

bind decoupled_tag_cache dtc_checker #(
  .SETS(SETS), .TWAYS(TWAYS), .NSLOT(NSLOT),
  .SET_W(SET_W), .TWAY_W(TWAY_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot),
  .scan_ptr(scan_ptr), .slot_vld(slot_vld), .sown_set(sown_set),
  .sown_way(sown_way), .tv(tv), .tfwd(tfwd)
);

// File: tb/sim_decoupled_tag_cache.sv
`timescale 1ns/1ps
module sim_decoupled_tag_cache;
  localparam int SET_W = 2, DWAYS = 2, TAG_W = 8;
  localparam int SETS = 1 << SET_W, TW = 2 * DWAYS, NS = SETS * DWAYS;
  localparam int SLOT_W = $clog2(NS);

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [TAG_W+SET_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [SLOT_W-1:0] rsp_slot;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  decoupled_tag_cache #(.SET_W(SET_W), .DWAYS(DWAYS), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot)
  );

  // reference model, built from the requirements
  bit m_tv [SETS][TW];
  int m_tt [SETS][TW], m_fwd [SETS][TW], m_age [SETS][TW];
  bit m_sv [NS];
  int m_os [NS], m_ow [NS], m_cnt [NS];
  int m_ptr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mk(input int tag, input int set);
    return tag * SETS + set;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < TW; w++) begin
        m_tv[s][w] = 0; m_tt[s][w] = 0; m_fwd[s][w] = 0; m_age[s][w] = w;
      end
    for (int i = 0; i < NS; i++) begin m_sv[i] = 0; m_os[i] = 0; m_ow[i] = 0; m_cnt[i] = 0; end
    m_ptr = 0;
  endtask

  task automatic m_touch(input int s, input int w);
    int a = m_age[s][w];
    for (int v = 0; v < TW; v++)
      if (v == w) m_age[s][v] = 0;
      else if (m_age[s][v] < a) m_age[s][v]++;
  endtask

  task automatic m_access(input int addr, output bit hit, output int slot, output int lat);
    int s = addr % SETS;
    int t = addr / SETS;
    int way = -1, fr = -1;
    for (int w = 0; w < TW; w++) if (m_tv[s][w] && m_tt[s][w] == t) way = w;
    for (int w = TW - 1; w >= 0; w--) if (!m_tv[s][w]) fr = w;
    if (way >= 0) begin
      hit = 1; slot = m_fwd[s][way]; lat = 1;
      if (m_cnt[slot] < 3) m_cnt[slot]++;
      m_touch(s, way);
      return;
    end
    hit = 0;
    if (fr >= 0) begin
      way = fr; lat = 2;
      while (m_cnt[m_ptr] != 0) begin
        m_cnt[m_ptr]--; m_ptr = (m_ptr + 1) % NS; lat++;
      end
      slot = m_ptr; m_ptr = (m_ptr + 1) % NS; lat++;
    end else begin
      for (int w = 0; w < TW; w++) if (m_age[s][w] == TW - 1) way = w;
      slot = m_fwd[s][way]; lat = 2;
    end
    if (m_sv[slot]) m_tv[m_os[slot]][m_ow[slot]] = 0;
    m_tv[s][way] = 1; m_tt[s][way] = t; m_fwd[s][way] = slot;
    m_sv[slot] = 1; m_os[slot] = s; m_ow[slot] = way; m_cnt[slot] = 0;
    m_touch(s, way);
  endtask

  // one request through the port; compares hit, slot and latency with the model
  task automatic do_req(input int addr, input string req, output bit got_hit, output int got_slot);
    bit eh; int es, el, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = (TAG_W+SET_W)'(addr);
    m_access(addr, eh, es, el);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 64) begin
      chk(req_ready == 1'b0, {req, "/R2 busy"}, int'(req_ready), 0);
      @(negedge clk); n++;
    end
    got_hit = rsp_hit; got_slot = int'(rsp_slot);
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, int'(rsp_valid), 1);
    chk(rsp_hit == eh, {req, " hit"}, int'(rsp_hit), int'(eh));
    chk(int'(rsp_slot) == es, {req, " slot"}, int'(rsp_slot), es);
    chk(n == el, {req, "/R4 latency"}, n, el);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_cold();
    bit h; int sl;
    do_req(mk(1, 0), "R8 cold miss", h, sl);
    chk(h == 0 && sl == 0, "R8 first slot", sl, 0);
    do_req(mk(1, 0), "R1 hit", h, sl);
    chk(h == 1 && sl == 0, "R1 hit slot", sl, 0);
    for (int i = 1; i < NS; i++) begin
      do_req(mk(1 + i / SETS, i % SETS), "R4 fill", h, sl);
      chk(sl == i, "R4 in-order empty slot", sl, i);
    end
  endtask

  task automatic t_cross();
    bit h; int sl;
    do_req(mk(3, 0), "R6 global victim", h, sl);
    chk(sl == 1, "R6 slot from set1", sl, 1);
    do_req(mk(1, 1), "R6 old owner", h, sl);
    chk(h == 0, "R6 invalidated tag misses", int'(h), 0);
  endtask

  task automatic t_lru();
    bit h; int sl;
    do_req(mk(4, 0), "R7 last free way", h, sl);
    do_req(mk(5, 0), "R7 lru reuse", h, sl);
    chk(sl == 0, "R7 lru slot reused", sl, 0);
    do_req(mk(1, 0), "R7 evicted lru", h, sl);
    chk(h == 0, "R7 evicted block misses", int'(h), 0);
    do_req(mk(9, 2), "R5 ptr kept", h, sl);
    chk(sl == 4, "R5 sweep resumes", sl, 4);
  endtask

  task automatic t_busy();
    bit h; int sl, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = (TAG_W+SET_W)'(mk(40, 3));
    m_access(mk(40, 3), h, sl, n);
    @(posedge clk);
    @(negedge clk);
    req_addr = (TAG_W+SET_W)'(mk(41, 3));
    n = 1;
    while (!rsp_valid && n < 64) begin
      chk(req_ready == 1'b0, "R2 held request waits", int'(req_ready), 0);
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    chk(rsp_hit == 1'b0 && int'(rsp_slot) == sl, "R2 first request answered", int'(rsp_slot), sl);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 held request not answered", int'(rsp_valid), 0);
    do_req(mk(41, 3), "R2 held request not installed", h, sl);
    chk(h == 0, "R2 held block absent", int'(h), 0);
  endtask

  task automatic t_sat();
    bit h; int sl;
    for (int i = 0; i < 6; i++) do_req(mk(9, 2), "R3 repeat hit", h, sl);
    do_req(mk(2, 1), "R3 second block", h, sl);
    do_req(mk(2, 1), "R3 second hit", h, sl);
    for (int i = 0; i < 24; i++) do_req(mk(60 + i, i % SETS), "R3 sweep stream", h, sl);
    for (int i = 0; i < 12; i++) do_req(mk(60 + i, i % SETS), "R5 revisit", h, sl);
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cold();
    t_cross();
    t_lru();
    t_busy();
    t_sat();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule